// File: doc/BRIEF.md
# Shift-Accumulate-Rectify Datapath Stage

This stage sits behind a multiply-accumulate array and conditions each product word before it reaches later processing. A programmable arithmetic shifter first scales the incoming signed word. Right shifts divide with round-half-up, and left shifts multiply. The scaled word, together with the rounding bit from a right shift, is added in one operation to a second operand. That operand is either the cascade input bus or zero, so several stages can be chained or a stage can run on its own.

The signed sum is wrapped to the data width and can be passed through unchanged, half-wave rectified or full-wave rectified. The result is then registered onto the output bus. Two separate flags travel with each output sample. One reports a true sum above the largest positive value, and the other reports a true sum below the most negative value, so downstream consumers know in which direction the data is wrong. A valid strobe accompanies the data in both directions. The stage has one cycle of latency.

Top module: `sar_stage`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `out_vld`, `out_data`, `out_povf` and `out_novf` are all zero.
- R2: A sample accepted with `in_vld` high appears on the outputs with `out_vld` high exactly one clock later. In a cycle after `in_vld` was low, `out_vld` is low and `out_data`, `out_povf` and `out_novf` keep their previous values.
- R3: When `ctrl[5]` is 0, the input is shifted arithmetically right by `ctrl[4:1]` places, and amounts above 8 count as 8. When the amount is nonzero, the last bit shifted out (input bit amount−1) is added into the same sum as the shifted word.
- R4: When `ctrl[5]` is 1, the input is shifted left by `ctrl[4:1]` places, and amounts above 8 count as 8. Bits moved beyond the data width are discarded and no rounding bit is added.
- R5: `ctrl[0]` = 0 adds the cascade bus `casc_in` as the second operand. `ctrl[0]` = 1 adds zero instead.
- R6: `out_povf` is 1 exactly when the true signed sum of shifted word, rounding bit and second operand exceeds 2^21−1. The sum is then wrapped to 22 bits before rectification.
- R7: `out_novf` is 1 exactly when the true sum is below −2^21. Operands of opposite sign never raise either flag, and the two flags are never 1 together.
- R8: `ctrl[7:6]` selects the rectifier. With 00 the wrapped sum passes unchanged. With 01 negative values become 0. With 10 or 11 the output is the absolute value, and −2^21 saturates to 2^21−1. The overflow flags do not depend on this mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Input sample strobe |
| in_data | input | 22 | Signed product word from the array |
| casc_in | input | 22 | Signed cascade operand |
| ctrl | input | 8 | [7:6] rectifier mode, [5] shift direction, [4:1] shift amount, [0] zero-operand select |
| out_vld | output | 1 | Output sample strobe |
| out_data | output | 22 | Signed, rectified result |
| out_povf | output | 1 | Positive overflow of the addition |
| out_novf | output | 1 | Negative overflow of the addition |

## Verification
Every result of this stage, including the data word, both overflow flags and the valid strobe, is due on the first rising edge after the inputs are presented. No result takes a second cycle. The bench drives inputs on falling edges. At the next falling edge, before driving the next sample, it compares the outputs with the expectation a behavioural integer model computed for the previous drive. Idle cycles carry a hold expectation rather than a new one.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int CTRL_W = 8;

  typedef enum logic [1:0] {
    RECT_PASS  = 2'b00,
    RECT_HALF  = 2'b01,
    RECT_FULL  = 2'b10,
    RECT_FULLB = 2'b11
  } rect_mode_t;

  typedef struct packed {
    logic       go_left;
    logic [3:0] amount;
  } shift_ctl_t;

  typedef struct packed {
    rect_mode_t rect;
    shift_ctl_t shift;
    logic       zero_b;
  } stage_ctl_t;
endpackage

// File: rtl/sar_shifter.sv
module sar_shifter
  import sar_pkg::*;
#(
  parameter int W      = 22,
  parameter int MAX_SH = 8
) (
  input  logic [W-1:0] din,
  input  shift_ctl_t   ctl,
  output logic [W-1:0] shifted,
  output logic         round_bit
);
  localparam logic [3:0] MAX_AMT = 4'(MAX_SH);

  logic [3:0] amt_eff;

  function automatic logic [W-1:0] shr_arith(input logic [W-1:0] v, input logic [3:0] n);
    return W'($signed(v) >>> n);
  endfunction

  function automatic logic last_out(input logic [W-1:0] v, input logic [3:0] n);
    logic [W-1:0] t;
    if (n == 4'd0) return 1'b0;
    t = v >> (n - 4'd1);
    return t[0];
  endfunction

  always_comb begin
    amt_eff = (ctl.amount > MAX_AMT) ? MAX_AMT : ctl.amount;
    if (ctl.go_left) begin
      shifted   = din << amt_eff;
      round_bit = 1'b0;
    end else begin
      shifted   = shr_arith(din, amt_eff);
      round_bit = last_out(din, amt_eff);
    end
  end
endmodule

// File: rtl/sar_adder.sv
module sar_adder #(
  parameter int W = 22
) (
  input  logic [W-1:0] op_a,
  input  logic         rnd,
  input  logic [W-1:0] casc,
  input  logic         zero_b,
  output logic [W-1:0] sum,
  output logic         pos_ovf,
  output logic         neg_ovf
);
  localparam int XW = W + 2;

  logic [W-1:0]  op_b;
  logic [XW-1:0] wide;

  function automatic logic [XW-1:0] ext_add(input logic [W-1:0] a, input logic [W-1:0] b,
                                            input logic r);
    return {{2{a[W-1]}}, a} + {{2{b[W-1]}}, b} + XW'(r);
  endfunction

  always_comb begin
    op_b    = zero_b ? '0 : casc;
    wide    = ext_add(op_a, op_b, rnd);
    sum     = wide[W-1:0];
    pos_ovf = !wide[XW-1] && (wide[W] || wide[W-1]);
    neg_ovf = wide[XW-1] && !(wide[W] && wide[W-1]);
  end
endmodule

// File: rtl/sar_rectifier.sv
module sar_rectifier
  import sar_pkg::*;
#(
  parameter int W = 22
) (
  input  logic [W-1:0] din,
  input  rect_mode_t   mode,
  output logic [W-1:0] dout
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

  function automatic logic [W-1:0] abs_sat(input logic [W-1:0] v);
    if (!v[W-1])       return v;
    if (v == MOST_NEG) return MOST_POS;
    return (~v) + 1'b1;
  endfunction

  always_comb begin
    unique case (mode)
      RECT_PASS:            dout = din;
      RECT_HALF:            dout = din[W-1] ? '0 : din;
      RECT_FULL, RECT_FULLB: dout = abs_sat(din);
      default:              dout = din;
    endcase
  end
endmodule

// File: rtl/sar_stage.sv
module sar_stage
  import sar_pkg::*;
#(
  parameter int DATA_W    = 22,
  parameter int MAX_SHIFT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] in_data,
  input  logic [DATA_W-1:0] casc_in,
  input  logic [CTRL_W-1:0] ctrl,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_data,
  output logic              out_povf,
  output logic              out_novf
);
  localparam int MSB = DATA_W - 1;

  stage_ctl_t        ctl;
  logic [DATA_W-1:0] shifted_w;
  logic              round_w;
  logic [DATA_W-1:0] sum_w;
  logic              povf_w;
  logic              novf_w;
  logic [DATA_W-1:0] rect_w;
  logic              opp_sign_w;

  assign ctl        = stage_ctl_t'(ctrl);
  assign opp_sign_w = !ctl.zero_b && (shifted_w[MSB] != casc_in[MSB]);

  sar_shifter #(.W(DATA_W), .MAX_SH(MAX_SHIFT)) u_shift (
    .din      (in_data),
    .ctl      (ctl.shift),
    .shifted  (shifted_w),
    .round_bit(round_w)
  );

  sar_adder #(.W(DATA_W)) u_add (
    .op_a   (shifted_w),
    .rnd    (round_w),
    .casc   (casc_in),
    .zero_b (ctl.zero_b),
    .sum    (sum_w),
    .pos_ovf(povf_w),
    .neg_ovf(novf_w)
  );

  sar_rectifier #(.W(DATA_W)) u_rect (
    .din (sum_w),
    .mode(ctl.rect),
    .dout(rect_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_data <= '0;
      out_povf <= 1'b0;
      out_novf <= 1'b0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        out_data <= rect_w;
        out_povf <= povf_w;
        out_novf <= novf_w;
      end
    end
  end

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> (!out_vld && $stable(out_data) && $stable(out_povf) && $stable(out_novf)));

  // R7
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_povf && out_novf));

  // R7
  opp_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && opp_sign_w) |=> (!out_povf && !out_novf));

  // R8
  half_wave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && ctl.rect == RECT_HALF) |=> !out_data[MSB]);

  // R5
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && ctrl == 8'h01) |=> (out_data == $past(in_data) && !out_povf && !out_novf));
endmodule

// File: tb/sar_stage_bench.sv
`timescale 1ns/1ps
module sar_stage_bench;
  localparam longint HALF = 64'sd2097152;
  localparam longint FULL = 64'sd4194304;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_vld;
  logic [21:0] in_data;
  logic [21:0] casc_in;
  logic [7:0]  ctrl;
  logic        out_vld;
  logic [21:0] out_data;
  logic        out_povf;
  logic        out_novf;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic        e_vld;
  logic [21:0] e_data;
  logic        e_p, e_n;
  string       e_tag;

  always #2 clk = ~clk;

  sar_stage u_sar_stage (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_data(in_data),
    .casc_in(casc_in), .ctrl(ctrl), .out_vld(out_vld), .out_data(out_data),
    .out_povf(out_povf), .out_novf(out_novf)
  );

  function automatic longint wrap22(input longint x);
    longint t;
    t = x & 64'h3FFFFF;
    if (t >= HALF) t = t - FULL;
    return t;
  endfunction

  function automatic void model(input logic [21:0] d, input logic [21:0] c, input logic [7:0] ct,
                                output logic [21:0] o, output logic p, output logic n);
    longint v, cv, q, r, s, w;
    int amt;
    v = wrap22(longint'(d));
    cv = wrap22(longint'(c));
    amt = int'(ct[4:1]);
    if (amt > 8) amt = 8;
    if (!ct[5]) begin
      q = v >>> amt;
      r = (amt > 0) ? ((v >>> (amt - 1)) & 1) : 0;
    end else begin
      q = wrap22(v <<< amt);
      r = 0;
    end
    s = q + r + (ct[0] ? 0 : cv);
    p = (s > HALF - 1);
    n = (s < -HALF);
    w = wrap22(s);
    if (ct[7:6] == 2'b01 && w < 0) w = 0;
    if (ct[7] && w < 0) w = (w == -HALF) ? HALF - 1 : -w;
    o = w[21:0];
  endfunction

  task automatic compare();
    checks++;
    if (out_vld !== e_vld || out_data !== e_data || out_povf !== e_p || out_novf !== e_n) begin
      failures++;
      $display("FAIL %s: got vld=%b data=%h p=%b n=%b, expected vld=%b data=%h p=%b n=%b",
               e_tag, out_vld, out_data, out_povf, out_novf, e_vld, e_data, e_p, e_n);
    end
  endtask

  task automatic step(input logic v, input logic [21:0] d, input logic [21:0] c,
                      input logic [7:0] ct, input string tag);
    logic [21:0] o;
    logic p, n;
    @(negedge clk);
    compare();
    in_vld = v; in_data = d; casc_in = c; ctrl = ct;
    e_vld = v;
    e_tag = tag;
    if (v) begin
      model(d, c, ct, o, p, n);
      e_data = o; e_p = p; e_n = n;
    end
  endtask

  initial begin
    rst_n = 1'b0; in_vld = 1'b0; in_data = '0; casc_in = '0; ctrl = '0;
    e_vld = 0; e_data = '0; e_p = 0; e_n = 0; e_tag = "R1";
    repeat (3) @(negedge clk);
    compare(); // R1 during reset
    rst_n = 1'b1;
    step(0, 22'h0, 22'h0, 8'h00, "R1");
    // R3 rounding and clamping
    step(1, 22'd7, 22'h0, 8'b00_0_0001_1, "R3");
    step(1, 22'h3FFFF9, 22'h0, 8'b00_0_0010_1, "R3");
    step(1, 22'h1FFFFF, 22'h0, 8'b00_0_1111_1, "R3");
    step(1, 22'h0000FF, 22'h0, 8'b00_0_1000_1, "R3");
    // R4 left shift
    step(1, 22'd3, 22'h0, 8'b00_1_1000_1, "R4");
    step(1, 22'h0FFFFF, 22'h0, 8'b00_1_1101_1, "R4");
    // R5 operand select
    step(1, 22'd100, 22'd23, 8'b00_0_0000_0, "R5");
    step(1, 22'd100, 22'd23, 8'b00_0_0000_1, "R5");
    // R6 / R7 overflow
    step(1, 22'h1FFFFF, 22'd1, 8'h00, "R6");
    step(1, 22'h200000, 22'h3FFFFF, 8'h00, "R7");
    step(1, 22'h1FFFFF, 22'h200000, 8'h00, "R7");
    step(1, 22'h1FFFFF, 22'h1FFFFF, 8'b10_0_0000_0, "R6");
    // R8 rectifier
    step(1, 22'h3FFFF0, 22'h0, 8'b01_0_0000_1, "R8");
    step(1, 22'h200000, 22'h0, 8'b10_0_0000_1, "R8");
    step(1, 22'h3FFFF0, 22'h0, 8'b11_0_0000_1, "R8");
    step(1, 22'h3FFFF0, 22'h0, 8'b00_0_0000_1, "R8");
    // R2 idle hold
    step(0, 22'h12345, 22'h54321, 8'hFF, "R2");
    step(0, 22'h0, 22'h0, 8'h00, "R2");
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] ct;
      ct = 8'($urandom);
      step(($urandom % 5) != 0, 22'($urandom), 22'($urandom), ct, ct[5] ? "R4" : "R3");
    end
    step(0, 22'h0, 22'h0, 8'h00, "R2");
    @(negedge clk);
    compare();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule